// File: doc/BRIEF.md
# Clock root control register file

This block is the software-facing control store for a clock root generator. Software programs a source selection, a half-integer pre-divider, a counter mode, a hardware-control flag and three M/N/D counter values through a 32-bit word-addressed port. All of these writes land in shadow copies. The datapath that drives the divider and multiplexer sees only a separate active copy. The active copy is loaded from the shadows in a single commit.

A commit begins when software writes 1 to the update bit of the command word. The bit then reads back as 1 while the switch is in flight. A small state machine counts out a fixed commit latency, which stands in for the time the glitch-free multiplexer needs. On the final cycle the whole shadow set is copied into the active outputs, and the update bit drops by itself. Per-register pending flags show which shadows have changed since the last commit. A force bit keeps the root on whatever the downstream enable does. A root-off flag, visible both as a port and in the command word, reports when the root is stopped.

The state machine has two states. In `ST_IDLE` it waits for a request. The transition *request* (an update write while none is pending) loads the latency counter and moves it to `ST_HOLD`. In `ST_HOLD` it counts down. The transition *apply* (counter at zero) raises the commit pulse for one cycle and returns to `ST_IDLE`.

Top module: `clk_root_regs`

## Requirements
- R1: After reset, every shadow value, every active output, the force bit, the update bit, the pending flags and the read data are zero, and the root-off output equals the inverse of the root-enable input.
- R2: Word 1 (configuration) reads back the divider in bits [DIV_W-1:0], the source select in [10:8], the mode in [13:12] and the hardware-control flag in bit 20, with all other bits zero. Words 2, 3 and 4 hold M, N and D in their low MND_W bits. Words 5 to 7 read as zero.
- R3: Writes to words 1 to 4 while no update is pending leave every active output unchanged.
- R4: Writing 1 to bit 0 of word 0 (command) makes that bit read 1 until the commit edge, after which it reads 0. Writing 0 to bit 0 never clears it.
- R5: The active outputs change only on the clock edge that falls COMMIT_LAT cycles after the edge that accepted the update request. At that edge they take the shadow values held just before it.
- R6: An update request written while one is already pending is ignored and does not restart the latency count. A shadow written during the wait is committed with its latest value.
- R7: Command bits 4, 5, 6 and 7 flag pending changes to the configuration, N, M and D words respectively. Each flag sets on a write to its word and clears at a commit edge, unless its word is written on that same edge.
- R8: Command bit 1 is a read/write force-on bit. The root-off output and command bit 31 read 1 exactly when the root-enable input is low and the force bit is clear.
- R9: Read data is registered. It changes on the edge that samples a read strobe, shows the addressed word as it stood before that edge, and holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| root_en_i | input | 1 | Downstream request to run the root |
| root_off_o | output | 1 | High when the root is stopped |
| act_src | output | 3 | Active source select |
| act_div | output | DIV_W | Active half-integer divider code |
| act_mode | output | 2 | Active counter mode |
| act_hw_ctl | output | 1 | Active hardware-control flag |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
The commit path is tested with four patterns. A plain request followed by idle cycles pins the exact edge of the commit. A second request inside the wait window, together with a shadow rewrite, shows whether the count restarts and whether the latest shadow is the one captured. A shadow write landing on the commit edge itself separates "flag cleared" from "flag kept", and it also shows whether the active copy took the old value or the new one. Idle stretches of shadow writes with no request show that the active outputs are isolated from the shadows. The force and root-enable combinations run through all four cases of the root-off flag.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    // word indices
    localparam int W_CMD = 0;
    localparam int W_CFG = 1;
    localparam int W_M   = 2;
    localparam int W_N   = 3;
    localparam int W_D   = 4;

    // command word bit positions
    localparam int CMD_UPD_B   = 0;
    localparam int CMD_FORCE_B = 1;
    localparam int CMD_DIRTY_B = 4;
    localparam int CMD_OFF_B   = 31;

    // configuration word bit positions
    localparam int CFG_SRC_LO = 8;
    localparam int CFG_MOD_LO = 12;
    localparam int CFG_HWC_B  = 20;

    // pending-flag index: 0 cfg, 1 N, 2 M, 3 D
    localparam int DIRTY_N = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } commit_state_e;

    typedef struct packed {
        logic       hw_ctl;
        logic [1:0] mode;
        logic [2:0] src;
    } sel_cfg_t;

    // pending-flag index of M/N/D slot i (slot 0 M, 1 N, 2 D)
    function automatic int mnd_dirty_idx(input int i);
        case (i)
            0:       return 2;
            1:       return 1;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/cr_commit_fsm.sv
module cr_commit_fsm #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic commit_o,
    output logic busy_o
);
    import clkroot_pkg::*;

    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    commit_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: request (IDLE->HOLD), apply (HOLD->IDLE)
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_W'(LAT - 1);
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        commit_o = 1'b0;
        busy_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                commit_o = 1'b0;
                busy_o   = 1'b0;
            end
            ST_HOLD: begin
                commit_o = (cnt_q == '0);
                busy_o   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cr_shadow_regs.sv
module cr_shadow_regs #(
    parameter int DIV_W = 5,
    parameter int MND_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic                             bus_rd,
    input  logic [clkroot_pkg::ADDR_W-1:0]   bus_addr,
    input  logic [clkroot_pkg::BUS_W-1:0]    bus_wdata,
    output logic [clkroot_pkg::BUS_W-1:0]    bus_rdata,
    input  logic                             root_en_i,
    input  logic                             commit_i,
    output logic                             req_o,
    output logic                             pend_o,
    output logic                             force_o,
    output logic [clkroot_pkg::DIRTY_N-1:0]  dirty_o,
    output logic                             root_off_o,
    output clkroot_pkg::sel_cfg_t            sh_sel,
    output logic [DIV_W-1:0]                 sh_div,
    output logic [2:0][MND_W-1:0]            sh_mnd
);
    import clkroot_pkg::*;

    logic                 pend_q, force_q;
    logic [DIRTY_N-1:0]   dirty_q, dirty_set;
    logic [BUS_W-1:0]     rd_mux;
    logic                 wr_cmd, wr_cfg;
    logic [2:0]           wr_mnd;
    sel_cfg_t             sel_q;
    logic [DIV_W-1:0]     div_q;
    logic                 unused_wbits;

    assign unused_wbits = ^bus_wdata;

    assign wr_cmd = bus_wr && (bus_addr == ADDR_W'(W_CMD));
    assign wr_cfg = bus_wr && (bus_addr == ADDR_W'(W_CFG));
    assign req_o  = wr_cmd && bus_wdata[CMD_UPD_B] && !pend_q;
    assign root_off_o = !root_en_i && !force_q;

    // M/N/D shadow slots
    for (genvar i = 0; i < 3; i++) begin : g_mnd
        localparam int WORD = W_M + i;
        localparam int DIDX = mnd_dirty_idx(i);
        logic [MND_W-1:0] val_q;

        assign wr_mnd[i]       = bus_wr && (bus_addr == ADDR_W'(WORD));
        assign dirty_set[DIDX] = wr_mnd[i];
        assign sh_mnd[i]       = val_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_mnd[i]) begin
                val_q <= bus_wdata[MND_W-1:0];
            end
        end
    end

    assign dirty_set[0] = wr_cfg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            force_q <= 1'b0;
            dirty_q <= '0;
            sel_q   <= '0;
            div_q   <= '0;
        end else begin
            if (commit_i) begin
                pend_q <= 1'b0;
            end else if (req_o) begin
                pend_q <= 1'b1;
            end
            if (wr_cmd) begin
                force_q <= bus_wdata[CMD_FORCE_B];
            end
            if (wr_cfg) begin
                div_q        <= bus_wdata[DIV_W-1:0];
                sel_q.src    <= bus_wdata[CFG_SRC_LO +: 3];
                sel_q.mode   <= bus_wdata[CFG_MOD_LO +: 2];
                sel_q.hw_ctl <= bus_wdata[CFG_HWC_B];
            end
            dirty_q <= dirty_set | (dirty_q & {DIRTY_N{!commit_i}});
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(W_CMD)) begin
            rd_mux[CMD_UPD_B]                   = pend_q;
            rd_mux[CMD_FORCE_B]                 = force_q;
            rd_mux[CMD_DIRTY_B +: DIRTY_N]      = dirty_q;
            rd_mux[CMD_OFF_B]                   = root_off_o;
        end else if (bus_addr == ADDR_W'(W_CFG)) begin
            rd_mux[DIV_W-1:0]                   = div_q;
            rd_mux[CFG_SRC_LO +: 3]             = sel_q.src;
            rd_mux[CFG_MOD_LO +: 2]             = sel_q.mode;
            rd_mux[CFG_HWC_B]                   = sel_q.hw_ctl;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (bus_addr == ADDR_W'(W_M + i)) begin
                    rd_mux[MND_W-1:0] = sh_mnd[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign pend_o  = pend_q;
    assign force_o = force_q;
    assign dirty_o = dirty_q;
    assign sh_sel  = sel_q;
    assign sh_div  = div_q;

endmodule

// File: rtl/cr_active_regs.sv
module cr_active_regs #(
    parameter int DIV_W = 5,
    parameter int MND_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_i,
    input  clkroot_pkg::sel_cfg_t  sh_sel,
    input  logic [DIV_W-1:0]       sh_div,
    input  logic [2:0][MND_W-1:0]  sh_mnd,
    output clkroot_pkg::sel_cfg_t  act_sel,
    output logic [DIV_W-1:0]       act_div,
    output logic [2:0][MND_W-1:0]  act_mnd
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel <= '0;
            act_div <= '0;
        end else if (commit_i) begin
            act_sel <= sh_sel;
            act_div <= sh_div;
        end
    end

    for (genvar i = 0; i < 3; i++) begin : g_act
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_mnd[i] <= '0;
            end else if (commit_i) begin
                act_mnd[i] <= sh_mnd[i];
            end
        end
    end

endmodule

// File: rtl/clk_root_regs.sv
module clk_root_regs #(
    parameter int DIV_W      = 5,
    parameter int MND_W      = 8,
    parameter int COMMIT_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              root_en_i,
    output logic              root_off_o,
    output logic [2:0]        act_src,
    output logic [DIV_W-1:0]  act_div,
    output logic [1:0]        act_mode,
    output logic              act_hw_ctl,
    output logic [MND_W-1:0]  act_m,
    output logic [MND_W-1:0]  act_n,
    output logic [MND_W-1:0]  act_d
);
    import clkroot_pkg::*;

    logic                 req_p, commit_p, busy;
    logic                 pend, force_on;
    logic [DIRTY_N-1:0]   dirty;
    sel_cfg_t             sh_sel, act_sel;
    logic [DIV_W-1:0]     sh_div;
    logic [2:0][MND_W-1:0] sh_mnd, act_mnd;

    cr_shadow_regs #(.DIV_W(DIV_W), .MND_W(MND_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .root_en_i  (root_en_i),
        .commit_i   (commit_p),
        .req_o      (req_p),
        .pend_o     (pend),
        .force_o    (force_on),
        .dirty_o    (dirty),
        .root_off_o (root_off_o),
        .sh_sel     (sh_sel),
        .sh_div     (sh_div),
        .sh_mnd     (sh_mnd)
    );

    cr_commit_fsm #(.LAT(COMMIT_LAT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_p),
        .commit_o (commit_p),
        .busy_o   (busy)
    );

    cr_active_regs #(.DIV_W(DIV_W), .MND_W(MND_W)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_p),
        .sh_sel   (sh_sel),
        .sh_div   (sh_div),
        .sh_mnd   (sh_mnd),
        .act_sel  (act_sel),
        .act_div  (act_div),
        .act_mnd  (act_mnd)
    );

    assign act_src    = act_sel.src;
    assign act_mode   = act_sel.mode;
    assign act_hw_ctl = act_sel.hw_ctl;
    assign act_m      = act_mnd[0];
    assign act_n      = act_mnd[1];
    assign act_d      = act_mnd[2];

endmodule

// File: rtl/cr_root_chk.sv
module cr_root_chk #(
    parameter int ACT_W = 35
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             root_en_i,
    input logic             root_off_o,
    input logic             commit_p,
    input logic             busy,
    input logic             pend,
    input logic             force_on,
    input logic [3:0]       dirty,
    input logic [ACT_W-1:0] act_all
);

    // R3: with no update pending, the active set holds on the next edge
    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(act_all));

    // R4: the update bit drops right after a commit
    a_r4_update_clears: assert property (@(posedge clk) disable iff (!rst_n)
        commit_p |=> !pend);

    // R5: a commit only happens while a request is pending
    a_r5_commit_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        commit_p |-> (pend && busy));

    // R6: the sequencer and the update bit agree at all times
    a_r6_pend_tracks_fsm: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> busy);

    // R7: commit with no concurrent write leaves no pending flag
    a_r7_dirty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_p && !bus_wr) |=> (dirty == 4'b0000));

    // R8: an enabled root or a forced root never reads as off
    a_r8_root_on: assert property (@(posedge clk) disable iff (!rst_n)
        (root_en_i || force_on) |-> !root_off_o);

endmodule

bind clk_root_regs cr_root_chk #(.ACT_W(3 + DIV_W + 3 + 3 * MND_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .root_en_i  (root_en_i),
    .root_off_o (root_off_o),
    .commit_p   (commit_p),
    .busy       (busy),
    .pend       (pend),
    .force_on   (force_on),
    .dirty      (dirty),
    .act_all    ({act_src, act_div, act_mode, act_hw_ctl, act_m, act_n, act_d})
);

// File: tb/clk_root_regs_tb.sv
module clk_root_regs_tb;

    localparam int DIV_W = 5;
    localparam int MND_W = 8;
    localparam int LAT   = 4;
    localparam logic [31:0] CFG_MASK = 32'((1 << DIV_W) - 1) | 32'h0010_3700;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              root_en_i = 1'b0;
    logic              root_off_o;
    logic [2:0]        act_src;
    logic [DIV_W-1:0]  act_div;
    logic [1:0]        act_mode;
    logic              act_hw_ctl;
    logic [MND_W-1:0]  act_m, act_n, act_d;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    clk_root_regs #(.DIV_W(DIV_W), .MND_W(MND_W), .COMMIT_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .root_en_i(root_en_i), .root_off_o(root_off_o),
        .act_src(act_src), .act_div(act_div), .act_mode(act_mode),
        .act_hw_ctl(act_hw_ctl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_pend, m_force;
    int          m_cnt;
    bit [3:0]    m_dirty;            // 0 cfg, 1 N, 2 M, 3 D
    int          m_cfg;              // masked configuration word
    int          m_mnd [3];          // 0 M, 1 N, 2 D
    int          a_cfg;
    int          a_mnd [3];
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        logic [31:0] v = '0;
        case (a)
            3'd0: begin
                v[0] = m_pend; v[1] = m_force; v[7:4] = m_dirty;
                v[31] = !root_en_i && !m_force;
            end
            3'd1: v = 32'(m_cfg);
            3'd2: v = 32'(m_mnd[0]);
            3'd3: v = 32'(m_mnd[1]);
            3'd4: v = 32'(m_mnd[2]);
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_force = 0; m_cnt = 0; m_dirty = 0; m_cfg = 0;
            a_cfg = 0; m_rdata = '0;
            for (int i = 0; i < 3; i++) begin m_mnd[i] = 0; a_mnd[i] = 0; end
        end else begin
            automatic bit old_pend = m_pend;
            automatic bit commit = m_pend && (m_cnt == 0);
            automatic logic [31:0] rv = m_read(bus_addr);
            if (commit) begin
                a_cfg = m_cfg;
                for (int i = 0; i < 3; i++) a_mnd[i] = m_mnd[i];
                m_pend = 0;
                m_dirty = 0;
            end else if (m_pend) begin
                m_cnt--;
            end
            if (bus_rd) m_rdata = rv;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        m_force = bus_wdata[1];
                        if (bus_wdata[0] && !old_pend) begin
                            m_pend = 1; m_cnt = LAT - 1;
                        end
                    end
                    3'd1: begin m_cfg = int'(bus_wdata & CFG_MASK); m_dirty[0] = 1; end
                    3'd2: begin m_mnd[0] = int'(bus_wdata[MND_W-1:0]); m_dirty[2] = 1; end
                    3'd3: begin m_mnd[1] = int'(bus_wdata[MND_W-1:0]); m_dirty[1] = 1; end
                    3'd4: begin m_mnd[2] = int'(bus_wdata[MND_W-1:0]); m_dirty[3] = 1; end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic [31:0] acfg = 32'(a_cfg);
            chk("R5 act_src",  32'(act_src),    32'(acfg[10:8]));
            chk("R5 act_div",  32'(act_div),    32'(acfg[DIV_W-1:0]));
            chk("R5 act_mode", 32'(act_mode),   32'(acfg[13:12]));
            chk("R5 act_hw",   32'(act_hw_ctl), 32'(acfg[20]));
            chk("R5 act_m",    32'(act_m),      32'(a_mnd[0]));
            chk("R5 act_n",    32'(act_n),      32'(a_mnd[1]));
            chk("R5 act_d",    32'(act_d),      32'(a_mnd[2]));
            chk("R9 rdata",    bus_rdata,       m_rdata);
            chk("R8 root_off", 32'(root_off_o), 32'(!root_en_i && !m_force));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 active", {act_src, act_div, act_m}, 32'h0);
        chk("R1 root_off", 32'(root_off_o), 32'h1);

        // R2 layout
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'h0000_00AB);
        wr(3'd3, 32'h0000_01CD);
        wr(3'd4, 32'h0000_0012);
        rd(3'd1); chk("R2 cfg mask", bus_rdata, CFG_MASK);
        rd(3'd3); chk("R2 N trunc", bus_rdata, 32'h0000_00CD);
        rd(3'd5); chk("R2 unmapped", bus_rdata, 32'h0);

        // R3 no commit without request
        repeat (6) @(negedge clk);
        chk("R3 src held", 32'(act_src), 32'h0);
        chk("R3 m held", 32'(act_m), 32'h0);
        // R9 read data holds
        chk("R9 hold", bus_rdata, 32'h0);
        rd(3'd0); chk("R7 dirty all", bus_rdata, 32'h8000_00F0);

        // R4/R5 basic commit
        wr(3'd0, 32'h1);                          // edge E0
        rd(3'd0); chk("R4 upd reads 1", bus_rdata, 32'h8000_00F1); // E1
        wr(3'd0, 32'h0);                          // E2: writing 0 keeps bit
        repeat (LAT - 3) @(negedge clk);          // after E(LAT-1)
        chk("R5 not early", 32'(act_src), 32'h0);
        @(negedge clk);                           // after E(LAT)
        chk("R5 src", 32'(act_src), 32'h7);
        chk("R5 div", 32'(act_div), 32'h1F);
        chk("R5 mnd", {8'h0, act_m, act_n, act_d}, 32'h00AB_CD12);
        rd(3'd0); chk("R4 upd cleared", bus_rdata, 32'h8000_0000);

        // R6 request during wait is ignored, latest shadow taken
        wr(3'd1, 32'h0000_0302);
        wr(3'd0, 32'h1);                          // E0
        wr(3'd1, 32'h0000_0504);                  // E1
        wr(3'd0, 32'h1);                          // E2 ignored
        repeat (LAT - 3) @(negedge clk);
        chk("R6 before", 32'(act_src), 32'h7);
        @(negedge clk);
        chk("R6 src latest", 32'(act_src), 32'h5);
        chk("R6 div latest", 32'(act_div), 32'h4);
        repeat (3) @(negedge clk);
        chk("R6 no second", 32'(act_src), 32'h5);

        // R7 write on the commit edge keeps its flag
        wr(3'd0, 32'h1);                          // E0
        repeat (LAT - 1) @(negedge clk);
        wr(3'd2, 32'h0000_0055);                  // E(LAT)
        chk("R7 old M committed", 32'(act_m), 32'h0000_00AB);
        rd(3'd0); chk("R7 M flag kept", bus_rdata, 32'h8000_0040);

        // R8 force and enable
        wr(3'd0, 32'h2);
        chk("R8 forced on", 32'(root_off_o), 32'h0);
        rd(3'd0); chk("R8 cmd forced", bus_rdata, 32'h0000_0042);
        root_en_i = 1'b1;
        wr(3'd0, 32'h0);
        chk("R8 enabled", 32'(root_off_o), 32'h0);
        root_en_i = 1'b0;
        #1;
        chk("R8 off", 32'(root_off_o), 32'h1);
        @(negedge clk);
        finish_run();
    end

endmodule